// File: doc/BRIEF.md
# Double-Buffered Two-Compare Timer

This block is a 16-bit up-counting timer for a peripheral bus. It advances once for each pulse of a chosen tick source. A tick source is any single-cycle enable in the system clock domain, for example the underflow strobe of a neighbouring timer. A period compare value sets the length of each cycle: the count runs from zero up to that value and then returns to zero. A phase compare value sets a point inside the period where a set-reset flip-flop goes high. The flip-flop goes low again at the period match, so the timer output is a square wave with a programmable duty offset. Each period match also gives a one-cycle pulse and, when enabled, an interrupt request.

Each compare register can feed the comparators directly. It can also feed them through a shadow copy. In shadow mode a new compare value written by software only takes effect when the counter reaches the value currently held in that shadow. A period change therefore never cuts a cycle short or lets the count run past it. Software prepares the shadows by writing to their addresses; the written data is discarded and the shadow takes the current compare value.

All accesses are single 16-bit writes. The write address selects one of five targets: 0 mode, 1 period compare, 2 phase compare, 3 period shadow load, 4 phase shadow load. Other addresses are ignored.

Top module: `dbt_timer`

## Requirements
- R1: After a synchronous active-low reset, `tmr_out`, `match_o` and `irq_o` are low, the counter is zero and the mode register is zero, so the timer does not count.
- R2: With mode bit 15 (run) set, every pulse of the selected tick source adds one to the counter. On a tick where the counter equals the effective period compare value P, the counter returns to zero and `match_o` is high for exactly one cycle. The period is therefore P+1 ticks.
- R3: `irq_o` pulses in the same cycle as `match_o` only when mode bit 12 (interrupt enable) is set; otherwise it stays low.
- R4: On a tick where the counter equals the effective phase compare value, `tmr_out` goes high. On a period match it goes low, and the period match wins if both happen on one tick. A phase value of 0xFFFF never sets it.
- R5: A mode write with bit 15 clear, or with bit 14 (initialise) set, clears the counter and `tmr_out` to zero in the write cycle.
- R6: A write of 0x0000 or 0xFFFF to the period compare register is ignored and leaves the previous value in effect.
- R7: Mode bits 2:0 select one of eight tick inputs. Pulses on the other inputs, and all pulses while bit 15 is clear, do not change the count.
- R8: With mode bit 5 (shadow mode) set, the counter is compared against the two shadow registers. On a tick where the counter equals a shadow's value, that shadow reloads from its compare register.
- R9: A write to address 3 or 4 loads the matching shadow from its compare register, whatever the write data.
- R10: With mode bit 5 clear, a new compare value is used from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target (0 mode, 1 period, 2 phase, 3/4 shadow loads) |
| wr_data | input | 16 | Write data |
| src_tick | input | 8 | Candidate tick enables, one per source |
| tmr_out | output | 1 | Flip-flop output, high from phase match to period match |
| match_o | output | 1 | One-cycle period-match pulse |
| irq_o | output | 1 | One-cycle interrupt request on period match when enabled |

## Verification
Some properties are checked on every cycle. An interrupt is never raised without a period-match pulse. Period-match pulses are never back to back. The output is low whenever a match pulse is shown. The counter stays at zero while the timer is stopped. An illegal period write leaves the compare value unchanged. A shadow never changes except on a load write or its own match. Other behaviours can only be shown by the bench scenarios, which compare each cycle's outputs against an independent model. These are the exact period and phase positions, the point at which a new compare value takes effect with and without shadows, the discarded shadow-load data, and the deselected tick inputs.

// File: rtl/dbt_pkg.sv
// Shared constants for the double-buffered timer: write addresses and
// mode register bit positions. Assumes a data width of at least 16 bits.
package dbt_pkg;
    localparam int ADDR_MODE  = 0;
    localparam int ADDR_CMPA  = 1;
    localparam int ADDR_CMPB  = 2;
    localparam int ADDR_SHA   = 3;
    localparam int ADDR_SHB   = 4;

    localparam int MB_RUN     = 15;
    localparam int MB_INIT    = 14;
    localparam int MB_IRQEN   = 12;
    localparam int MB_DBUF    = 5;

    localparam int NUM_CH     = 2;  // channel 0 = period, channel 1 = phase
endpackage

// File: rtl/dbt_regs.sv
// Register file of the timer: mode, period compare and phase compare.
// Decodes writes into clear and shadow-load strobes and picks the tick
// source. Assumes writes are whole words and at most one per cycle.
module dbt_regs
    import dbt_pkg::*;
#(
    parameter int W    = 16,
    parameter int NSRC = 8,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [NSRC-1:0] src_tick,
    output logic          run,
    output logic          tick,
    output logic          clr,
    output logic          irq_en,
    output logic          dbuf,
    output logic [W-1:0]  cmp_a,
    output logic [W-1:0]  cmp_b,
    output logic          ld_sh_a,
    output logic          ld_sh_b
);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [W-1:0] CMPA_RST = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0]  mode_q;
    logic [SW-1:0] sel;
    logic          wr_mode, wr_a, wr_b, a_legal;

    // Address decode of the single write port.
    always_comb begin
        wr_mode = wr_en && (wr_addr == AW'(ADDR_MODE));
        wr_a    = wr_en && (wr_addr == AW'(ADDR_CMPA));
        wr_b    = wr_en && (wr_addr == AW'(ADDR_CMPB));
        ld_sh_a = wr_en && (wr_addr == AW'(ADDR_SHA));
        ld_sh_b = wr_en && (wr_addr == AW'(ADDR_SHB));
        a_legal = (wr_data != '0) && (wr_data != '1);
        clr     = wr_mode && (!wr_data[MB_RUN] || wr_data[MB_INIT]);
    end

    // Mode fields and the selected, qualified tick.
    always_comb begin
        run    = mode_q[MB_RUN];
        irq_en = mode_q[MB_IRQEN];
        dbuf   = mode_q[MB_DBUF];
        sel    = mode_q[SW-1:0];
        tick   = run && src_tick[sel];
    end

    // Register storage; illegal period values are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            cmp_a  <= CMPA_RST;
            cmp_b  <= '0;
        end else begin
            if (wr_mode)            mode_q <= wr_data;
            if (wr_a && a_legal)    cmp_a  <= wr_data;
            if (wr_b)               cmp_b  <= wr_data;
        end
    end

    p_bad_period_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !a_legal) |=> $stable(cmp_a));
endmodule

// File: rtl/dbt_shadow.sv
// One compare channel: a shadow register and the equality detector.
// In shadow mode the counter is compared with the shadow, which reloads
// from the compare register on its own match; otherwise the compare
// register is used directly.
module dbt_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dbuf,
    input  logic         ld,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         hit
);
    logic [W-1:0] sh_q;
    logic [W-1:0] eff;

    // Effective compare value and the qualified match.
    always_comb begin
        eff = dbuf ? sh_q : cmp;
        hit = tick && (cnt == eff);
    end

    // Shadow update: explicit load first, then reload on its own match.
    always_ff @(posedge clk) begin
        if (!rst_n)              sh_q <= '0;
        else if (ld)             sh_q <= cmp;
        else if (dbuf && hit)    sh_q <= cmp;
    end

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !hit) |=> $stable(sh_q));
endmodule

// File: rtl/dbt_core.sv
// Counter with the two compare channels. Counts qualified ticks and
// wraps to zero on a period match. Assumes clr and tick are never
// both meaningful; clear has priority.
module dbt_core
    import dbt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    input  logic         dbuf,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         ld_sh_a,
    input  logic         ld_sh_b,
    output logic         hit_a,
    output logic         hit_b
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cmp_v [NUM_CH];
    logic         ld_v  [NUM_CH];
    logic         hit_v [NUM_CH];

    // Gather per-channel inputs for the generated channels.
    always_comb begin
        cmp_v[0] = cmp_a;
        cmp_v[1] = cmp_b;
        ld_v[0]  = ld_sh_a;
        ld_v[1]  = ld_sh_b;
        hit_a    = hit_v[0];
        hit_b    = hit_v[1];
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dbt_shadow #(.W(W)) u_sh (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .dbuf (dbuf),
            .ld   (ld_v[ch]),
            .cnt  (cnt_q),
            .cmp  (cmp_v[ch]),
            .hit  (hit_v[ch])
        );
    end

    // Up counter: clear, wrap on period match, else step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (tick)     cnt_q <= hit_a ? '0 : cnt_q + 1'b1;
    end

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (cnt_q == '0));
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/dbt_out.sv
// Output stage: the set-reset flip-flop, the match pulse and the
// interrupt request, all registered. Period match beats phase match.
module dbt_out (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit_a,
    input  logic hit_b,
    input  logic irq_en,
    output logic tmr_out,
    output logic match_o,
    output logic irq_o
);
    // Flip-flop: clear, reset on period match, set on phase match.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmr_out <= 1'b0;
        else if (clr)     tmr_out <= 1'b0;
        else if (hit_a)   tmr_out <= 1'b0;
        else if (hit_b)   tmr_out <= 1'b1;
    end

    // One-cycle match pulse and gated interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            match_o <= hit_a && !clr;
            irq_o   <= hit_a && !clr && irq_en;
        end
    end

    p_irq_with_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> match_o);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
    p_low_at_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> !tmr_out);
endmodule

// File: rtl/dbt_timer.sv
// Top of the double-buffered two-compare timer. Joins the register
// file, counter with shadow channels, and output stage. Assumes every
// tick input is a one-cycle enable synchronous to clk.
module dbt_timer #(
    parameter int W    = 16,
    parameter int NSRC = 8,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [NSRC-1:0] src_tick,
    output logic            tmr_out,
    output logic            match_o,
    output logic            irq_o
);
    logic         run, tick, clr, irq_en, dbuf, ld_sh_a, ld_sh_b;
    logic         hit_a, hit_b;
    logic [W-1:0] cmp_a, cmp_b;

    dbt_regs #(.W(W), .NSRC(NSRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_tick(src_tick), .run(run), .tick(tick),
        .clr(clr), .irq_en(irq_en), .dbuf(dbuf), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .ld_sh_a(ld_sh_a), .ld_sh_b(ld_sh_b)
    );

    dbt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .clr(clr),
        .dbuf(dbuf), .cmp_a(cmp_a), .cmp_b(cmp_b), .ld_sh_a(ld_sh_a),
        .ld_sh_b(ld_sh_b), .hit_a(hit_a), .hit_b(hit_b)
    );

    dbt_out u_out (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hit_a(hit_a), .hit_b(hit_b),
        .irq_en(irq_en), .tmr_out(tmr_out), .match_o(match_o), .irq_o(irq_o)
    );
endmodule

// File: tb/tb_dbt_timer.sv
module tb_dbt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  src_tick = '0;
    logic        tmr_out, match_o, irq_o;

    int total = 0;
    int bad = 0;
    logic [2:0] exp_q [$];
    string      tag_q [$];

    // Reference model state, built from the requirements.
    logic [15:0] m_mode, m_a, m_b, m_sha, m_shb, m_cnt;
    logic        m_ff;

    localparam logic [15:0] RUN = 16'h8000, INIT = 16'h4000,
                            IE = 16'h1000, DBUF = 16'h0020;

    dbt_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_tick(src_tick), .tmr_out(tmr_out),
        .match_o(match_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic push(input logic m, input logic irq, input string t);
        exp_q.push_back({m_ff, m, irq});
        tag_q.push_back(t);
    endtask

    task automatic wr(input int addr, input logic [15:0] d, input string t);
        @(negedge clk);
        src_tick = '0; wr_en = 1'b1; wr_addr = 3'(addr); wr_data = d;
        case (addr)
            0: begin
                if (!d[15] || d[14]) begin m_cnt = '0; m_ff = 1'b0; end
                m_mode = d;
            end
            1: if (d != 16'h0000 && d != 16'hFFFF) m_a = d;
            2: m_b = d;
            3: m_sha = m_a;
            4: m_shb = m_b;
            default: ;
        endcase
        push(1'b0, 1'b0, t);
    endtask

    task automatic tk(input int idx, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            logic [15:0] ea, eb;
            logic ha, hb;
            @(negedge clk);
            wr_en = 1'b0; src_tick = 8'(1 << idx);
            ha = 1'b0;
            if (m_mode[15] && idx == int'(m_mode[2:0])) begin
                ea = m_mode[5] ? m_sha : m_a;
                eb = m_mode[5] ? m_shb : m_b;
                ha = (m_cnt == ea);
                hb = (m_cnt == eb);
                if (ha) m_ff = 1'b0; else if (hb) m_ff = 1'b1;
                m_cnt = ha ? 16'h0 : m_cnt + 16'h1;
                if (m_mode[5] && ha) m_sha = m_a;
                if (m_mode[5] && hb) m_shb = m_b;
            end
            push(ha, ha && m_mode[12], t);
        end
    endtask

    // Monitor: pop one expected item per driven cycle and compare.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({tmr_out, match_o, irq_o} !== e) begin
                    bad++;
                    $display("FAIL %s: {out,match,irq} actual=%b expected=%b",
                             t, {tmr_out, match_o, irq_o}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_mode = '0; m_a = 16'hFFFE; m_b = '0; m_sha = '0; m_shb = '0;
        m_cnt = '0; m_ff = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if ({tmr_out, match_o, irq_o} !== 3'b000) begin
            bad++;
            $display("FAIL R1: actual=%b expected=000", {tmr_out, match_o, irq_o});
        end
        tk(0, 3, "R1 idle after reset");
        // Direct mode, period 5, phase 2.
        wr(1, 16'd4, "R2"); wr(2, 16'd1, "R4");
        wr(0, RUN | IE, "R5 run no clear");
        tk(0, 12, "R2 R4");
        tk(1, 3, "R7 other source");
        tk(0, 2, "R2");
        wr(1, 16'h0000, "R6"); wr(1, 16'hFFFF, "R6");
        tk(0, 10, "R6 period kept");
        wr(0, IE, "R5 stop clears");
        tk(0, 3, "R7 stopped");
        wr(0, RUN | IE | 16'd3, "R7 select 3");
        tk(0, 2, "R7 deselected");
        tk(3, 6, "R7 source 3");
        wr(0, RUN | 16'd3, "R3");
        tk(3, 10, "R3 irq off");
        wr(1, 16'd2, "R10");
        tk(3, 8, "R10 new period now");
        wr(2, 16'hFFFF, "R4");
        tk(3, 8, "R4 phase never");
        wr(2, 16'd2, "R4"); wr(1, 16'd2, "R4");
        tk(3, 6, "R4 period beats phase");
        wr(0, RUN | INIT | IE, "R5 init clears");
        // Shadow mode.
        wr(1, 16'd4, "R8"); wr(2, 16'd1, "R8");
        wr(3, 16'h1234, "R9 data ignored");
        wr(4, 16'hABCD, "R9 data ignored");
        wr(0, RUN | IE | DBUF, "R8");
        tk(0, 7, "R8");
        wr(1, 16'd2, "R8 deferred"); wr(2, 16'd0, "R8 deferred");
        tk(0, 14, "R8 shadow reload");
        wr(1, 16'd6, "R9"); wr(3, 16'h0000, "R9 load now");
        tk(0, 10, "R9");
        @(negedge clk);
        src_tick = '0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule